// File: doc/BRIEF.md
# PLL Divider Source Selector and Reset Sequencer

This block decides which divider factors a clock-generation PLL runs with and when that PLL and the clock tree behind it must be reset. The feedback factor N (6 bits) and the reference factor M (5 bits) can come from two software-written configuration registers, from an 11-bit bank of strap pins, or from built-in fixed values. Which source applies depends on whether the chip is controlled over a parallel microcontroller bus or over a serial interface, and on a flexible/fixed clocking bit held in a small control register.

Whenever the divider pair the PLL uses actually changes, the block issues a PLL reset pulse. Every PLL reset is mirrored on a clock-unit reset pulse. The clock-unit reset is also raised on its own when any line changes between E1 and T1 framing, without disturbing the PLL. Strap pins are asynchronous and are synchronized before use. Both reset outputs are pulses of a fixed length, and a new cause during a pulse restarts it.

Top module: `pll_cfg_rst_ctrl`

## Requirements
- R1: After reset, flexible clocking is selected, both configuration registers hold N=33 and M=0, the outputs show N=33 and M=0, and neither reset output is high.
- R2: With the parallel interface (`if_serial`=0) and flexible clocking, a write to address 0 loads N from `cfg_wdata[5:0]` and a write to address 1 loads M from `cfg_wdata[4:0]`; the new value appears on `div_n`/`div_m` in the cycle after the write is sampled.
- R3: In that mode, a write that changes a register's contents starts a PLL reset; rewriting the value already held starts none.
- R4: With fixed clocking (bit 0 of address 2 written as 0), the outputs are N=33 and M=0 whatever the registers or strap pins hold, and neither register writes nor strap changes start a PLL reset.
- R5: With the serial interface (`if_serial`=1) and flexible clocking, N is `strap_pins[5:0]` (most significant bit first, so 33 is 1,0,0,0,0,1) and M is `strap_pins[10:6]`; after a two-stage synchronizer the values reach the outputs three clock edges after the pins change, together with a PLL reset.
- R6: With the serial interface, writes to addresses 0 and 1 are discarded and leave the stored register contents unchanged.
- R7: Switching between fixed and flexible clocking, or between interfaces, starts a PLL reset only if the resulting N or M differs from the values in use before the switch.
- R8: Any change on `ch_t1` (0 = E1, 1 = T1 per line; record is all E1 after reset) raises `clk_rst` in the next cycle without raising `pll_rst`.
- R9: Whenever `pll_rst` is high, `clk_rst` is high too.
- R10: Each reset output stays high for exactly RST_LEN cycles (8 by default) after its latest cause; a new cause during a pulse restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| if_serial | input | 1 | 1 = serial control interface, 0 = parallel microcontroller bus |
| strap_pins | input | 11 | Strap bank, [5:0] = N, [10:6] = M, asynchronous |
| cfg_wr | input | 1 | Register write strobe, one cycle per write |
| cfg_addr | input | 2 | 0 = N register, 1 = M register, 2 = control (bit 0 = flexible), 3 = unused |
| cfg_wdata | input | 6 | Register write data |
| ch_t1 | input | 4 | Per-line framing mode, 1 = T1 |
| div_n | output | 6 | Active PLL feedback divider N |
| div_m | output | 5 | Active PLL reference divider M |
| pll_rst | output | 1 | PLL reset pulse, active high |
| clk_rst | output | 1 | Clock-unit reset pulse, active high |

## Verification
The assertions watch, on every cycle, that fixed clocking pins the outputs at 33 and 0, that a PLL reset is always accompanied by a clock-unit reset, that a line mode change is followed by a clock-unit reset, and that the PLL reset is high exactly during the RST_LEN cycles following each change of the active divider pair. Which input source feeds the outputs in each interface and clocking mode, that serial-mode writes are really discarded, the synchronizer latency, and that a mode switch to identical values stays quiet can only be shown by the bench's scenarios, compared cycle by cycle against its reference model.

// File: rtl/pllcfg_pkg.sv
package pllcfg_pkg;

    localparam int NDIV_W     = 6;
    localparam int MDIV_W     = 5;
    localparam int STRAP_W    = NDIV_W + MDIV_W;
    localparam int CFG_DATA_W = NDIV_W;
    localparam int CFG_ADDR_W = 2;

    // Packed so that the strap bank maps directly: M above N.
    typedef struct packed {
        logic [MDIV_W-1:0] m;
        logic [NDIV_W-1:0] n;
    } div_pair_t;

    typedef enum logic [CFG_ADDR_W-1:0] {
        CFG_N    = 2'd0,
        CFG_M    = 2'd1,
        CFG_CTRL = 2'd2,
        CFG_RSVD = 2'd3
    } cfg_addr_e;

endpackage

// File: rtl/pllcfg_sync.sv
module pllcfg_sync #(
    parameter int             W       = 8,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= RST_VAL;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= stg_d[i];
            end
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/pllcfg_div_select.sv
module pllcfg_div_select
    import pllcfg_pkg::*;
#(
    parameter int FIXED_N = 33,
    parameter int FIXED_M = 0
) (
    input  logic      flex_mode,
    input  logic      if_serial,
    input  div_pair_t reg_pair,
    input  div_pair_t strap_pair,
    output div_pair_t sel_pair
);

    localparam div_pair_t FIXED_PAIR = div_pair_t'({MDIV_W'(FIXED_M), NDIV_W'(FIXED_N)});

    always_comb begin
        if (!flex_mode) begin
            sel_pair = FIXED_PAIR;
        end else if (if_serial) begin
            sel_pair = strap_pair;
        end else begin
            sel_pair = reg_pair;
        end
    end

endmodule

// File: rtl/pllcfg_pulse.sv
module pllcfg_pulse #(
    parameter int LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic pulse
);

    localparam int CNT_W = $clog2(LEN + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (trig) begin
            cnt_d = CNT_W'(LEN);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign pulse = (cnt_q != '0);

endmodule

// File: rtl/pll_cfg_rst_ctrl.sv
module pll_cfg_rst_ctrl
    import pllcfg_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int SYNC_STAGES = 2,
    parameter int RST_LEN     = 8,
    parameter int FIXED_N     = 33,
    parameter int FIXED_M     = 0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  if_serial,
    input  logic [STRAP_W-1:0]    strap_pins,
    input  logic                  cfg_wr,
    input  logic [CFG_ADDR_W-1:0] cfg_addr,
    input  logic [CFG_DATA_W-1:0] cfg_wdata,
    input  logic [NUM_CH-1:0]     ch_t1,
    output logic [NDIV_W-1:0]     div_n,
    output logic [MDIV_W-1:0]     div_m,
    output logic                  pll_rst,
    output logic                  clk_rst
);

    localparam div_pair_t FIXED_PAIR = div_pair_t'({MDIV_W'(FIXED_M), NDIV_W'(FIXED_N)});

    typedef struct packed {
        div_pair_t         cfg;   // software-written divider pair
        logic              flex;  // 1 = flexible clocking
        logic [NUM_CH-1:0] ch;    // last seen line modes
        div_pair_t         act;   // divider pair in use
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    logic      flex_mode;
    logic      pll_trig;
    logic      clk_trig;
    div_pair_t strap_pair;
    div_pair_t sel_pair;
    logic [STRAP_W-1:0] strap_sync;

    assign flex_mode  = st_q.flex;
    assign strap_pair = div_pair_t'(strap_sync);

    pllcfg_sync #(
        .W       (STRAP_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (STRAP_W'(FIXED_PAIR))
    ) u_strap_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (strap_pins),
        .dout  (strap_sync)
    );

    pllcfg_div_select #(
        .FIXED_N (FIXED_N),
        .FIXED_M (FIXED_M)
    ) u_select (
        .flex_mode  (flex_mode),
        .if_serial  (if_serial),
        .reg_pair   (st_q.cfg),
        .strap_pair (strap_pair),
        .sel_pair   (sel_pair)
    );

    always_comb begin
        st_d = st_q;

        if (cfg_wr) begin
            case (cfg_addr_e'(cfg_addr))
                CFG_N: begin
                    if (!if_serial) begin
                        st_d.cfg.n = cfg_wdata[NDIV_W-1:0];
                    end
                end
                CFG_M: begin
                    if (!if_serial) begin
                        st_d.cfg.m = cfg_wdata[MDIV_W-1:0];
                    end
                end
                CFG_CTRL: begin
                    st_d.flex = cfg_wdata[0];
                end
                default: begin
                end
            endcase
        end

        st_d.ch  = ch_t1;
        st_d.act = sel_pair;

        pll_trig = (sel_pair != st_q.act);
        clk_trig = pll_trig || (ch_t1 != st_q.ch);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg  <= FIXED_PAIR;
            st_q.flex <= 1'b1;
            st_q.ch   <= '0;
            st_q.act  <= FIXED_PAIR;
        end else begin
            st_q <= st_d;
        end
    end

    pllcfg_pulse #(.LEN(RST_LEN)) u_pll_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (pll_trig),
        .pulse (pll_rst)
    );

    pllcfg_pulse #(.LEN(RST_LEN)) u_clk_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (clk_trig),
        .pulse (clk_rst)
    );

    assign div_n = st_q.act.n;
    assign div_m = st_q.act.m;

endmodule

// File: rtl/pllcfg_chk.sv
module pllcfg_chk
    import pllcfg_pkg::*;
#(
    parameter int NUM_CH  = 4,
    parameter int RST_LEN = 8,
    parameter int FIXED_N = 33,
    parameter int FIXED_M = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flex_mode,
    input logic [NUM_CH-1:0] ch_t1,
    input logic [NDIV_W-1:0] div_n,
    input logic [MDIV_W-1:0] div_m,
    input logic              pll_rst,
    input logic              clk_rst
);

    localparam int AGE_W = $clog2(RST_LEN + 1);

    logic [NUM_CH-1:0]         ch_prev_q;
    logic [NDIV_W+MDIV_W-1:0]  pair_prev_q;
    logic [AGE_W-1:0]          age_q;
    logic [AGE_W-1:0]          age_now;
    logic                      pair_chg;

    assign pair_chg = ({div_m, div_n} != pair_prev_q);

    always_comb begin
        if (pair_chg) begin
            age_now = '0;
        end else if (age_q == AGE_W'(RST_LEN)) begin
            age_now = age_q;
        end else begin
            age_now = age_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_prev_q   <= '0;
            pair_prev_q <= {MDIV_W'(FIXED_M), NDIV_W'(FIXED_N)};
            age_q       <= AGE_W'(RST_LEN);
        end else begin
            ch_prev_q   <= ch_t1;
            pair_prev_q <= {div_m, div_n};
            age_q       <= age_now;
        end
    end

    assert_fixed_values_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!flex_mode && $past(!flex_mode)) |-> (div_n == NDIV_W'(FIXED_N) && div_m == MDIV_W'(FIXED_M)));

    assert_line_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_t1 != ch_prev_q) |=> clk_rst);

    assert_pll_implies_clk_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pll_rst |-> clk_rst);

    // R3/R5/R7: a change of the active pair is always accompanied by a PLL reset.
    assert_pair_change_resets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pair_chg |-> pll_rst);

    assert_pulse_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pll_rst == (age_now < AGE_W'(RST_LEN)));

endmodule

bind pll_cfg_rst_ctrl pllcfg_chk #(
    .NUM_CH  (NUM_CH),
    .RST_LEN (RST_LEN),
    .FIXED_N (FIXED_N),
    .FIXED_M (FIXED_M)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flex_mode (flex_mode),
    .ch_t1     (ch_t1),
    .div_n     (div_n),
    .div_m     (div_m),
    .pll_rst   (pll_rst),
    .clk_rst   (clk_rst)
);

// File: tb/pll_cfg_rst_ctrl_test.sv
`timescale 1ns/1ps
module pll_cfg_rst_ctrl_test;

    localparam int RST_LEN = 8;
    localparam int FIX_N   = 33;
    localparam int FIX_M   = 0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        if_serial = 1'b0;
    logic [10:0] strap_pins = {5'd0, 6'd33};
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [5:0]  cfg_wdata = 6'd0;
    logic [3:0]  ch_t1 = 4'd0;
    logic [5:0]  div_n;
    logic [4:0]  div_m;
    logic        pll_rst;
    logic        clk_rst;

    int n_checks = 0;
    int n_fail   = 0;
    string phase = "R1";

    always #5 clk = ~clk;

    pll_cfg_rst_ctrl uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .if_serial  (if_serial),
        .strap_pins (strap_pins),
        .cfg_wr     (cfg_wr),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .ch_t1      (ch_t1),
        .div_n      (div_n),
        .div_m      (div_m),
        .pll_rst    (pll_rst),
        .clk_rst    (clk_rst)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge.
    int m_s1, m_s2, m_regn, m_regm, m_flex, m_ch, m_n, m_m, m_pcnt, m_ccnt;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 33; m_s2 = 33; m_regn = FIX_N; m_regm = FIX_M; m_flex = 1;
            m_ch = 0; m_n = FIX_N; m_m = FIX_M; m_pcnt = 0; m_ccnt = 0;
        end else begin
            int nn, nm;
            bit ptrig, ctrig;
            if (m_flex == 0) begin
                nn = FIX_N; nm = FIX_M;
            end else if (if_serial) begin
                nn = m_s2 % 64; nm = m_s2 / 64;
            end else begin
                nn = m_regn; nm = m_regm;
            end
            ptrig = (nn != m_n) || (nm != m_m);
            ctrig = ptrig || (int'(ch_t1) != m_ch);
            m_n = nn; m_m = nm;
            m_pcnt = ptrig ? RST_LEN : (m_pcnt > 0 ? m_pcnt - 1 : 0);
            m_ccnt = ctrig ? RST_LEN : (m_ccnt > 0 ? m_ccnt - 1 : 0);
            m_ch = int'(ch_t1);
            m_s2 = m_s1;
            m_s1 = int'(strap_pins);
            if (cfg_wr) begin
                if (cfg_addr == 2'd0 && !if_serial) m_regn = int'(cfg_wdata);
                if (cfg_addr == 2'd1 && !if_serial) m_regm = int'(cfg_wdata) % 32;
                if (cfg_addr == 2'd2) m_flex = int'(cfg_wdata[0]);
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk({phase, " model n"}, int'(div_n), m_n);
            chk({phase, " model m"}, int'(div_m), m_m);
            chk({phase, " model pll_rst"}, int'(pll_rst), int'(m_pcnt != 0));
            chk({phase, " model clk_rst"}, int'(clk_rst), int'(m_ccnt != 0));
        end
    end

    task automatic wr(input int addr, input int data);
        cfg_addr  = 2'(addr);
        cfg_wdata = 6'(data);
        cfg_wr    = 1'b1;
        @(negedge clk);
        cfg_wr    = 1'b0;
    endtask

    task automatic idle(input int cyc);
        repeat (cyc) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);

        phase = "R1";
        chk("R1 n after reset", int'(div_n), 33);
        chk("R1 m after reset", int'(div_m), 0);
        chk("R1 pll_rst after reset", int'(pll_rst), 0);
        chk("R1 clk_rst after reset", int'(clk_rst), 0);

        phase = "R2";
        wr(0, 20);
        @(negedge clk);
        chk("R2 n from register", int'(div_n), 20);
        chk("R3 pll_rst on content change", int'(pll_rst), 1);
        chk("R9 clk_rst with pll_rst", int'(clk_rst), 1);
        phase = "R10";
        idle(7);
        chk("R10 pll_rst last cycle", int'(pll_rst), 1);
        @(negedge clk);
        chk("R10 pll_rst ended", int'(pll_rst), 0);

        phase = "R3";
        wr(0, 20);
        @(negedge clk);
        chk("R3 no reset on same value", int'(pll_rst), 0);
        phase = "R2";
        wr(1, 7);
        @(negedge clk);
        chk("R2 m from register", int'(div_m), 7);
        idle(10);

        phase = "R10";
        wr(0, 21);
        @(negedge clk);
        chk("R10 first trigger", int'(pll_rst), 1);
        idle(3);
        wr(0, 22);
        @(negedge clk);
        idle(7);
        chk("R10 restarted pulse still high", int'(pll_rst), 1);
        @(negedge clk);
        chk("R10 restarted pulse ended", int'(pll_rst), 0);
        idle(4);

        phase = "R7";
        wr(2, 0);
        @(negedge clk);
        chk("R7 fixed n", int'(div_n), 33);
        chk("R7 reset on switch to fixed", int'(pll_rst), 1);
        idle(10);
        phase = "R4";
        wr(0, 5);
        @(negedge clk);
        chk("R4 n stays fixed", int'(div_n), 33);
        chk("R4 no reset on write", int'(pll_rst), 0);
        strap_pins = {5'd9, 6'd12};
        if_serial = 1'b1;
        idle(5);
        chk("R4 no reset on strap change", int'(pll_rst), 0);
        chk("R4 m stays fixed", int'(div_m), 0);
        if_serial = 1'b0;
        strap_pins = {5'd0, 6'd33};
        idle(4);

        phase = "R7";
        wr(2, 1);
        @(negedge clk);
        chk("R7 back to flexible n", int'(div_n), 5);
        chk("R7 reset on switch to flexible", int'(pll_rst), 1);
        idle(10);
        wr(0, 33);
        wr(1, 0);
        idle(10);
        wr(2, 0);
        @(negedge clk);
        chk("R7 no reset when values equal", int'(pll_rst), 0);
        wr(2, 1);
        idle(10);

        phase = "R8";
        ch_t1 = 4'b0010;
        @(negedge clk);
        chk("R8 clk_rst on line change", int'(clk_rst), 1);
        chk("R8 no pll_rst on line change", int'(pll_rst), 0);
        idle(10);

        phase = "R5";
        if_serial = 1'b1;
        idle(2);
        strap_pins = {5'd3, 6'd17};
        idle(2);
        chk("R5 synchronizer latency", int'(div_n), 33);
        @(negedge clk);
        chk("R5 n from straps", int'(div_n), 17);
        chk("R5 m from straps", int'(div_m), 3);
        chk("R5 pll_rst on strap change", int'(pll_rst), 1);
        idle(10);

        phase = "R6";
        wr(0, 9);
        @(negedge clk);
        chk("R6 no reset on serial write", int'(pll_rst), 0);
        if_serial = 1'b0;
        @(negedge clk);
        chk("R6 serial write discarded", int'(div_n), 33);
        chk("R6 m register unchanged", int'(div_m), 0);
        idle(10);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule